// File: doc/BRIEF.md
# Multi-Mask Selectable Fetch Decoder

This block sits in an instruction-fetch path. Program images are stored XOR-encoded, so that more of the stored bits take the value that is cheaper to read. Each fetched word carries a small selector field and a toggle bit above the instruction payload. The decoder holds several mask registers and strips the extra bits. When the toggle bit asks for it, the decoder XORs the payload with the selected mask and presents the restored instruction one cycle later, together with a valid flag.

The selector field names a mask register by index. The first word of every basic block carries an explicit index, even when that index is already in use. Every other word carries the all-ones code, which keeps the last selection. Register 0 holds the generic mask used outside the hot blocks, and the other registers hold block-specific masks. The mask registers are written through a small load port. That port works only while the core is held in reset, so the masks cannot change during execution.

Top module: `xm_fetch_decoder`

## Requirements
- R1: A fetched word is FETCH_W = INSTR_W + 1 + CTRL_W bits wide. Bits [FETCH_W-1 -: CTRL_W] form the selector code, bit [INSTR_W] is the toggle bit and bits [INSTR_W-1:0] are the payload. A word accepted with `fetch_valid` high appears decoded on `instr_data`, with `instr_valid` high, exactly one clock later. A cycle without `fetch_valid` gives `instr_valid` low one clock later.
- R2: CTRL_W = ceil(log2(NUM_MASKS)) with NUM_MASKS >= 3. The block holds NUM_MASKS-1 mask registers: index 0 is the generic mask and indices 1 to NUM_MASKS-2 are block-specific masks.
- R3: A selector code of all ones (3 with the default CTRL_W of 2) leaves the current selection unchanged. The word carrying it is decoded with that selection.
- R4: A selector code c below NUM_MASKS-1 selects mask register c. The change applies to the word that carries it and to the following words, and it applies whatever the toggle bit is. A code that is neither all ones nor below NUM_MASKS-1 keeps the selection.
- R5: With toggle bit 1 the output is the payload XOR the selected mask. With toggle bit 0 the output is the payload unchanged.
- R6: While `rst` is high (synchronous, active high), `instr_valid` is low one clock later. After reset the selection is index 0, the generic mask.
- R7: While `rst` is high, a write with `cfg_we` high loads `cfg_data` into mask register `cfg_addr`. A later reset can reload the masks. A write to an address of NUM_MASKS-1 or above changes no register.
- R8: Writes on the load port while `rst` is low are ignored, and the mask registers keep their values.
- R9: Fetched words presented while `rst` is high are ignored: they produce no output and do not change the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also opens the mask load port |
| cfg_we | input | 1 | Mask register write enable |
| cfg_addr | input | CTRL_W | Mask register index to write |
| cfg_data | input | INSTR_W | Mask value to write |
| fetch_valid | input | 1 | A fetched word is present |
| fetch_word | input | FETCH_W | Encoded word: selector, toggle, payload |
| instr_valid | output | 1 | Decoded instruction is valid |
| instr_data | output | INSTR_W | Decoded instruction |

## Verification
The assertions check on every cycle that the valid flag follows the fetch strobe by one clock. They also check that the keep code leaves the selection register alone, that an index code lands in it, that unmasked payloads pass through unchanged, and that the mask registers stay frozen outside reset. Only the bench scenarios can show that the restored instruction equals the payload XOR the correct mask across a mix of block switches. The same holds for a switch taking effect on its own word, a switch on an unmasked word still steering later words, load-port writes after reset having no effect, and words fetched during reset leaving the generic mask selected.

// File: rtl/xm_pkg.sv
package xm_pkg;

    typedef enum logic {
        SEL_HOLD = 1'b0,
        SEL_LOAD = 1'b1
    } sel_action_e;

    function automatic int unsigned ctrl_bits(input int unsigned n_masks);
        return $clog2(n_masks);
    endfunction

    function automatic sel_action_e classify_code(
        input logic [7:0]  code,
        input int unsigned ctrl_w,
        input int unsigned n_regs
    );
        int unsigned value;
        int unsigned keep_code;
        value     = int'(code);
        keep_code = (32'd1 << ctrl_w) - 32'd1;
        if (value == keep_code)
            return SEL_HOLD;
        else if (value < n_regs)
            return SEL_LOAD;
        else
            return SEL_HOLD;
    endfunction

endpackage

// File: rtl/xm_mask_bank.sv
module xm_mask_bank #(
    parameter int INSTR_W  = 32,
    parameter int NUM_REGS = 3,
    parameter int ADDR_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [INSTR_W-1:0] cfg_data,
    input  logic [ADDR_W-1:0]  rd_sel,
    output logic [INSTR_W-1:0] rd_mask
);

    logic [INSTR_W-1:0] mask_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst && cfg_we && (cfg_addr == ADDR_W'(g)))
                mask_q[g] <= cfg_data;
        end

        // R8: outside reset no mask register may move
        a_r8_mask_frozen: assert property (@(posedge clk) disable iff (rst)
            !rst |=> $stable(mask_q[g]));
    end

    always_comb begin
        rd_mask = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_sel == ADDR_W'(i))
                rd_mask = mask_q[i];
        end
    end

endmodule

// File: rtl/xm_sel_track.sv
module xm_sel_track
    import xm_pkg::*;
#(
    parameter int CTRL_W   = 2,
    parameter int NUM_REGS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_valid,
    input  logic [CTRL_W-1:0] ctrl_code,
    output logic [CTRL_W-1:0] eff_sel,
    output logic [CTRL_W-1:0] cur_sel
);

    sel_action_e action;

    always_comb begin
        action  = classify_code(8'(ctrl_code), CTRL_W, NUM_REGS);
        eff_sel = (action == SEL_LOAD) ? ctrl_code : cur_sel;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cur_sel <= '0;
        else if (word_valid)
            cur_sel <= eff_sel;
    end

    // R3: keep code leaves the selection alone
    a_r3_keep_holds: assert property (@(posedge clk) disable iff (rst)
        (word_valid && (ctrl_code == {CTRL_W{1'b1}})) |=> $stable(cur_sel));

    // R4: an in-range index lands in the selection register
    a_r4_index_loads: assert property (@(posedge clk) disable iff (rst)
        (word_valid && (int'(ctrl_code) < NUM_REGS)) |=> (cur_sel == $past(ctrl_code)));

    // R6: reset returns to the generic mask
    a_r6_reset_generic: assert property (@(posedge clk)
        rst |=> (cur_sel == '0));

endmodule

// File: rtl/xm_word_decode.sv
module xm_word_decode #(
    parameter int INSTR_W = 32,
    parameter int CTRL_W  = 2,
    parameter int FETCH_W = INSTR_W + 1 + CTRL_W
) (
    input  logic [FETCH_W-1:0] word,
    input  logic [INSTR_W-1:0] mask,
    output logic [CTRL_W-1:0]  ctrl_code,
    output logic               toggle,
    output logic [INSTR_W-1:0] payload,
    output logic [INSTR_W-1:0] decoded
);

    always_comb begin
        ctrl_code = word[FETCH_W-1 -: CTRL_W];
        toggle    = word[INSTR_W];
        payload   = word[INSTR_W-1:0];
        decoded   = toggle ? (payload ^ mask) : payload;
    end

endmodule

// File: rtl/xm_fetch_decoder.sv
module xm_fetch_decoder
    import xm_pkg::*;
#(
    parameter int INSTR_W   = 32,
    parameter int NUM_MASKS = 4,
    localparam int CTRL_W   = ctrl_bits(NUM_MASKS),
    localparam int FETCH_W  = INSTR_W + 1 + CTRL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic [CTRL_W-1:0]  cfg_addr,
    input  logic [INSTR_W-1:0] cfg_data,
    input  logic               fetch_valid,
    input  logic [FETCH_W-1:0] fetch_word,
    output logic               instr_valid,
    output logic [INSTR_W-1:0] instr_data
);

    localparam int NUM_REGS = NUM_MASKS - 1;

    initial begin
        a_r2_min_masks: assert (NUM_MASKS >= 3);
    end

    logic [CTRL_W-1:0]  ctrl_code;
    logic               toggle;
    logic [INSTR_W-1:0] payload;
    logic [INSTR_W-1:0] decoded;
    logic [CTRL_W-1:0]  eff_sel;
    logic [CTRL_W-1:0]  cur_sel;
    logic [INSTR_W-1:0] sel_mask;
    logic               take;

    assign take = fetch_valid && !rst;

    xm_word_decode #(
        .INSTR_W (INSTR_W),
        .CTRL_W  (CTRL_W),
        .FETCH_W (FETCH_W)
    ) u_decode (
        .word      (fetch_word),
        .mask      (sel_mask),
        .ctrl_code (ctrl_code),
        .toggle    (toggle),
        .payload   (payload),
        .decoded   (decoded)
    );

    xm_sel_track #(
        .CTRL_W   (CTRL_W),
        .NUM_REGS (NUM_REGS)
    ) u_sel (
        .clk        (clk),
        .rst        (rst),
        .word_valid (take),
        .ctrl_code  (ctrl_code),
        .eff_sel    (eff_sel),
        .cur_sel    (cur_sel)
    );

    xm_mask_bank #(
        .INSTR_W  (INSTR_W),
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (CTRL_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .rd_sel   (eff_sel),
        .rd_mask  (sel_mask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            instr_valid <= 1'b0;
            instr_data  <= '0;
        end else begin
            instr_valid <= fetch_valid;
            if (fetch_valid)
                instr_data <= decoded;
        end
    end

    // R1: valid follows the fetch strobe by one clock
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |=> instr_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |=> !instr_valid);

    // R5: unmasked words pass straight through
    a_r5_passthrough: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && !fetch_word[INSTR_W]) |=> (instr_data == $past(fetch_word[INSTR_W-1:0])));

    // R9: nothing comes out after a reset cycle
    a_r9_reset_quiet: assert property (@(posedge clk)
        rst |=> !instr_valid);

endmodule

// File: tb/tb_xm_fetch_decoder.sv
`timescale 1ns/1ps
module tb_xm_fetch_decoder;

    localparam int INSTR_W   = 32;
    localparam int NUM_MASKS = 4;
    localparam int CTRL_W    = 2;
    localparam int FETCH_W   = INSTR_W + 1 + CTRL_W;
    localparam int NUM_REGS  = NUM_MASKS - 1;
    localparam logic [CTRL_W-1:0] KEEP = '1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_we = 1'b0;
    logic [CTRL_W-1:0]  cfg_addr = '0;
    logic [INSTR_W-1:0] cfg_data = '0;
    logic               fetch_valid = 1'b0;
    logic [FETCH_W-1:0] fetch_word = '0;
    logic               instr_valid;
    logic [INSTR_W-1:0] instr_data;

    int checks = 0;
    int fails  = 0;
    logic [INSTR_W-1:0] model_mask [NUM_REGS];
    int unsigned model_sel = 0;

    always #10 clk = ~clk;

    xm_fetch_decoder #(
        .INSTR_W   (INSTR_W),
        .NUM_MASKS (NUM_MASKS)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_data    (cfg_data),
        .fetch_valid (fetch_valid),
        .fetch_word  (fetch_word),
        .instr_valid (instr_valid),
        .instr_data  (instr_data)
    );

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic chk(input string req, input logic [INSTR_W:0] act, input logic [INSTR_W:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [FETCH_W-1:0] mk(input logic [CTRL_W-1:0] code, input logic tog,
                                              input logic [INSTR_W-1:0] pay);
        return {code, tog, pay};
    endfunction

    // expected decode per R3/R4/R5, updating the model selection
    function automatic logic [INSTR_W-1:0] expect_word(input logic [FETCH_W-1:0] w);
        logic [CTRL_W-1:0] code;
        code = w[FETCH_W-1 -: CTRL_W];
        if (code != KEEP && int'(code) < NUM_REGS)
            model_sel = int'(code);
        return w[INSTR_W] ? (w[INSTR_W-1:0] ^ model_mask[model_sel]) : w[INSTR_W-1:0];
    endfunction

    task automatic send(input string req, input logic [FETCH_W-1:0] w);
        logic [INSTR_W-1:0] exp;
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_word  = w;
        exp = expect_word(w);
        @(negedge clk);
        chk(req, {instr_valid, instr_data}, {1'b1, exp});
        fetch_valid = 1'b0;
    endtask

    task automatic load_masks(input logic [INSTR_W-1:0] base);
        for (int i = 0; i < NUM_REGS; i++) begin
            @(negedge clk);
            cfg_we   = 1'b1;
            cfg_addr = CTRL_W'(i);
            cfg_data = base ^ (32'h1111_1111 * (i + 1));
            model_mask[i] = cfg_data;
        end
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_addr = KEEP;
        cfg_data = 32'hDEAD_BEEF;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        load_masks(32'hA5C3_0F96);
        @(negedge clk);
        chk("R6 valid low in reset", {instr_valid, 32'h0}, {1'b0, 32'h0});
        // R9: word during reset must be ignored
        fetch_valid = 1'b1;
        fetch_word  = mk(2'd2, 1'b1, 32'h1234_5678);
        @(negedge clk);
        chk("R9 no output in reset", {instr_valid, 32'h0}, {1'b0, 32'h0});
        fetch_valid = 1'b0;
        rst = 1'b0;
        // R8: write after reset ignored
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 2'd1; cfg_data = 32'hFFFF_0000;
        @(negedge clk);
        cfg_we = 1'b0;
        model_sel = 0;
        send("R6 R9 generic after reset", mk(KEEP, 1'b1, 32'h0F0F_0F0F));
        send("R4 R8 select on same word", mk(2'd1, 1'b1, 32'h0000_FFFF));
        send("R3 keep holds", mk(KEEP, 1'b1, 32'h1357_9BDF));
        send("R5 unmasked with switch", mk(2'd2, 1'b0, 32'hCAFE_F00D));
        send("R4 switch on unmasked steers next", mk(KEEP, 1'b1, 32'h0000_0000));
        send("R4 reselect same index", mk(2'd2, 1'b1, 32'hFFFF_FFFF));
        send("R4 back to generic", mk(2'd0, 1'b1, 32'h8000_0001));
        @(negedge clk);
        chk("R1 idle gives no valid", {instr_valid, 32'h0}, {1'b0, 32'h0});
        // R7: register for out-of-range address does not exist; mask 2 intact
        send("R7 out-of-range write harmless", mk(2'd2, 1'b1, 32'h0));

        for (int n = 0; n < 400; n++) begin
            logic [CTRL_W-1:0] code;
            code = ($urandom % 3 == 0) ? CTRL_W'($urandom % NUM_REGS) : KEEP;
            send("R1 R2 R5 random", mk(code, 1'($urandom), $urandom));
            if ($urandom % 8 == 0) begin
                @(negedge clk);
                chk("R1 random idle", {instr_valid, 32'h0}, {1'b0, 32'h0});
            end
        end

        // R7 reload in a second reset, R6 selection back to generic
        send("R4 pick 1 before reset", mk(2'd1, 1'b0, 32'h1));
        @(negedge clk);
        rst = 1'b1;
        load_masks(32'h3C3C_5A5A);
        @(negedge clk);
        rst = 1'b0;
        model_sel = 0;
        send("R6 R7 reload and generic", mk(KEEP, 1'b1, 32'h0000_0000));
        send("R7 reloaded mask 1", mk(2'd1, 1'b1, 32'h0000_0000));
        send("R7 reloaded mask 2", mk(2'd2, 1'b1, 32'hFFFF_FFFF));

        report();
        $finish;
    end

endmodule